// File: doc/BRIEF.md
# Dithered 10-bit PWM generator

This block turns an 8-bit high-time value and a 2-bit fine value into a pulse-width modulated output with 10 bits of effective resolution. The output period is a short interval of 256 count ticks. The output is high at the start of each short interval and stays high for the programmed number of ticks. Four short intervals make up a long interval. Within each long interval, the fine value picks how many of the four short intervals get one extra tick of high time. These extensions are placed so that they are spread across the long interval, which keeps the average duty at (4·n + fine) / 1024.

The count tick is a one-clock strobe from a prescaler that lives outside the block. The settings are captured when the generator is enabled and again at every long-interval boundary, so a write made in the middle of a long interval never produces a torn period. A one-clock pulse marks the end of every long interval, and it can be used as an interrupt request.

Stopping and restarting follow a fixed rule. If the output was high at the moment of the stop, it resumes immediately. If it was low, one short interval of low output is inserted before the pattern restarts.

Top module: `dither_pwm`

## Requirements
- R1: With the block enabled and settings n (`duty_n`) and fine value f (`duty_ext`), every short interval lasts 256 ticks. `pwm_out` is high during the first n+e ticks of the interval and low for the rest, where e is 0 or 1.
- R2: The short intervals of a long interval are numbered 0 to 3 in order. Interval k gets e = 1 under these conditions: never when f = 0; for k = 0 when f = 1; for k in {0, 2} when f = 2; for k in {0, 1, 2} when f = 3.
- R3: `duty_n` and `duty_ext` are sampled only in the clock after `en` rises and at each long-interval boundary. Changes at any other time have no effect on `pwm_out` until the next boundary.
- R4: `long_pulse` is high for exactly one clock, in the clock after the tick that ends each long interval of 1024 ticks. It is low at all other times.
- R5: While `en` is low, `pwm_out` is low from the next clock on, and the tick position returns to zero. A restart therefore always begins at interval 0, tick 0.
- R6: If `pwm_out` was high in the clock where `en` was sampled low, the next enable restarts the pattern at once.
- R7: If `pwm_out` was low in the clock where `en` was sampled low, the next enable first holds `pwm_out` low for 256 ticks and then starts the pattern at interval 0. The settings are re-sampled at that point.
- R8: n = 0 with f = 0 gives a constant low output. n = 255 in an extended interval gives a high output for all 256 ticks.
- R9: During reset, `pwm_out` and `long_pulse` are low, and the first enable after reset starts without delay.
- R10: The tick position advances only in clocks where `tick` is high. Without ticks the output holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Generator enable |
| tick | input | 1 | Count strobe, one tick per clock where high |
| duty_n | input | 8 | Base high time in ticks |
| duty_ext | input | 2 | Number of extended short intervals per long interval |
| pwm_out | output | 1 | Modulated output |
| long_pulse | output | 1 | One-clock strobe at the end of each long interval |

## Verification
A tick position that is off by one shows at the ports as a falling edge of `pwm_out` that comes one tick early or late, within the same short interval. A wrong interval number, or settings captured at the wrong time, move an extension into the wrong interval; this shows up within one long interval of 1024 ticks. A lost stop-level flag shows as a missing or extra 256-tick low gap in the first clocks after a restart. The reference model runs alongside the design in every clock, so each of these faults is reported in the clock where it first reaches `pwm_out` or `long_pulse`.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
   // Operating phase of the generator
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,   // disabled, counters at zero
      PH_GAP  = 2'd1,   // one low short interval before restart
      PH_RUN  = 2'd2    // producing the pattern
   } dpwm_phase_e;
endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
   import dpwm_pkg::*;
#(
   parameter int SUB_W = 8,
   parameter int SEG_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             pwm_now,
   output dpwm_phase_e      phase,
   output logic [SUB_W-1:0] sub,
   output logic [SEG_W-1:0] seg,
   output logic             load,
   output logic             long_done
);
   logic sub_last;
   logic seg_last;
   logic stop_low;

   assign sub_last = &sub;
   assign seg_last = &seg;

   // Settings are captured at start and whenever a long interval begins
   assign load = en && ((phase == PH_IDLE) ||
                        (tick && sub_last && ((phase == PH_GAP) || seg_last)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         sub       <= '0;
         seg       <= '0;
         stop_low  <= 1'b0;
         long_done <= 1'b0;
      end else begin
         long_done <= 1'b0;
         if (!en) begin
            if (phase != PH_IDLE) stop_low <= !pwm_now;
            phase <= PH_IDLE;
            sub   <= '0;
            seg   <= '0;
         end else if (phase == PH_IDLE) begin
            phase <= stop_low ? PH_GAP : PH_RUN;
            sub   <= '0;
            seg   <= '0;
         end else if (tick) begin
            sub <= sub + SUB_W'(1);
            if (sub_last) begin
               if (phase == PH_GAP) begin
                  phase <= PH_RUN;
               end else begin
                  seg <= seg + SEG_W'(1);
                  if (seg_last) long_done <= 1'b1;
               end
            end
         end
      end
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> (sub == '0 && seg == '0)); // R5
   AST_NO_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase != PH_IDLE) && $past(phase != PH_IDLE) && !$past(tick))
         |-> ($stable(sub) && $stable(seg))); // R10
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      long_done |=> !long_done); // R4
   AST_GAP_SEG0: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_GAP) |-> (seg == '0)); // R7
endmodule

// File: rtl/dpwm_width.sv
module dpwm_width #(
   parameter int SUB_W = 8,
   parameter int SEG_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SUB_W-1:0] duty_n,
   input  logic [SEG_W-1:0] duty_ext,
   input  logic [SEG_W-1:0] seg,
   output logic [SUB_W:0]   width
);
   logic [SUB_W-1:0] n_q;
   logic [SEG_W-1:0] ext_q;
   logic [SEG_W-1:0] seg_rev;
   logic             extend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q   <= '0;
         ext_q <= '0;
      end else if (load) begin
         n_q   <= duty_n;
         ext_q <= duty_ext;
      end
   end

   // Bit-reversed interval number spreads the extensions evenly
   for (genvar g = 0; g < SEG_W; g++) begin : g_rev
      assign seg_rev[g] = seg[SEG_W-1-g];
   end

   assign extend = (ext_q > seg_rev);
   assign width  = {1'b0, n_q} + (SUB_W+1)'(extend);

   AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(n_q) && $stable(ext_q))); // R3
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
   import dpwm_pkg::*;
#(
   parameter int SUB_W = 8,
   parameter int SEG_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic [SUB_W-1:0] duty_n,
   input  logic [SEG_W-1:0] duty_ext,
   output logic             pwm_out,
   output logic             long_pulse
);
   if (SUB_W < 2) begin : g_bad_sub
      $error("dither_pwm: SUB_W must be at least 2");
   end
   if (SEG_W < 1) begin : g_bad_seg
      $error("dither_pwm: SEG_W must be at least 1");
   end

   dpwm_phase_e      phase;
   logic [SUB_W-1:0] sub;
   logic [SEG_W-1:0] seg;
   logic [SUB_W:0]   width;
   logic             load;
   logic             pwm_w;

   dpwm_timebase #(.SUB_W(SUB_W), .SEG_W(SEG_W)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .tick      (tick),
      .pwm_now   (pwm_w),
      .phase     (phase),
      .sub       (sub),
      .seg       (seg),
      .load      (load),
      .long_done (long_pulse)
   );

   dpwm_width #(.SUB_W(SUB_W), .SEG_W(SEG_W)) u_wd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .duty_n   (duty_n),
      .duty_ext (duty_ext),
      .seg      (seg),
      .width    (width)
   );

   assign pwm_w   = (phase == PH_RUN) && ({1'b0, sub} < width);
   assign pwm_out = pwm_w;

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !pwm_out); // R5
endmodule

// File: tb/tb_dither_pwm.sv
module tb_dither_pwm;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] duty_n = 8'd0;
   logic [1:0] duty_ext = 2'd0;
   logic       pwm_out;
   logic       long_pulse;

   always #4 clk = ~clk;

   dither_pwm dut (
      .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
      .duty_n(duty_n), .duty_ext(duty_ext),
      .pwm_out(pwm_out), .long_pulse(long_pulse)
   );

   int    n_checks = 0;
   int    n_fail = 0;
   string cur_req = "R9";

   // Behavioural reference model state
   int m_run = 0, m_gap = 0, m_pos = 0, m_n = 0, m_e = 0, m_lastlow = 0, m_pulse = 0;

   function automatic int ext_on(int e, int k);
      case (e)
         1: return (k == 0) ? 1 : 0;
         2: return (k == 0 || k == 2) ? 1 : 0;
         3: return (k < 3) ? 1 : 0;
         default: return 0;
      endcase
   endfunction

   function automatic int model_pwm();
      if (m_run == 0 || m_gap != 0) return 0;
      return ((m_pos % 256) < (m_n + ext_on(m_e, m_pos / 256))) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_gap = 0; m_pos = 0; m_n = 0; m_e = 0; m_lastlow = 0; m_pulse = 0;
      end else begin
         m_pulse = 0;
         if (!en) begin
            if (m_run != 0) m_lastlow = (model_pwm() == 0) ? 1 : 0;
            m_run = 0; m_gap = 0; m_pos = 0;
         end else if (m_run == 0) begin
            m_run = 1; m_gap = m_lastlow; m_pos = 0;
            m_n = int'(duty_n); m_e = int'(duty_ext);
         end else if (tick) begin
            m_pos = m_pos + 1;
            if (m_gap != 0 && m_pos == 256) begin
               m_gap = 0; m_pos = 0;
               m_n = int'(duty_n); m_e = int'(duty_ext);
            end else if (m_gap == 0 && m_pos == 1024) begin
               m_pos = 0; m_pulse = 1;
               m_n = int'(duty_n); m_e = int'(duty_ext);
            end
         end
      end
   end

   task automatic check_outputs();
      int ep = model_pwm();
      n_checks++;
      if (pwm_out !== ep[0]) begin
         n_fail++;
         $display("FAIL %s pwm_out actual=%b expected=%0d at %0t", cur_req, pwm_out, ep, $time);
      end
      n_checks++;
      if (long_pulse !== m_pulse[0]) begin
         n_fail++;
         $display("FAIL R4 long_pulse actual=%b expected=%0d at %0t", long_pulse, m_pulse, $time);
      end
   endtask

   task automatic step(int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         check_outputs();
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      #(8 * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired, run hung");
      summary();
      $finish;
   end

   initial begin
      tick = 1'b1;
      cur_req = "R9";                       // reset state
      step(3);
      rst_n = 1'b1;
      // R1: plain pattern, no extension
      cur_req = "R1";
      duty_n = 8'd100; duty_ext = 2'd0; en = 1'b1;
      step(1100);
      // R2: each fine value
      cur_req = "R2";
      for (int e = 1; e < 4; e++) begin
         duty_ext = 2'(e); duty_n = 8'd37;
         step(2100);
      end
      // R3: changes inside a long interval wait for the boundary
      cur_req = "R3";
      for (int i = 0; i < 15; i++) begin
         duty_n = 8'(20 + 13 * i); duty_ext = 2'(i);
         step(200);
      end
      // R5/R6: stop while high, then restart
      duty_n = 8'd100; duty_ext = 2'd1;
      step(1100);
      cur_req = "R6";
      while (pwm_out !== 1'b1) step(1);
      en = 1'b0;
      cur_req = "R5";
      step(20);
      en = 1'b1;
      cur_req = "R6";
      step(600);
      // R7: stop while low, then restart with a gap
      cur_req = "R7";
      while (pwm_out !== 1'b1) step(1);
      while (pwm_out !== 1'b0) step(1);
      en = 1'b0;
      step(5);
      en = 1'b1;
      step(1500);
      // R8: extremes of the setting range
      cur_req = "R8";
      duty_n = 8'd0; duty_ext = 2'd0;
      step(2100);
      duty_n = 8'd255; duty_ext = 2'd3;
      step(2100);
      // R10: sparse ticks
      cur_req = "R10";
      duty_n = 8'd10; duty_ext = 2'd2;
      for (int i = 0; i < 4500; i++) begin
         tick = (i % 3 == 0);
         step(1);
      end
      summary();
      $finish;
   end
endmodule